// File: doc/BRIEF.md
# Flash ECC Error Capture Register

This block is a single 32-bit memory-mapped register for a flash controller. It records the first error-correction event that the flash read-path decoder reports. The decoder presents four one-cycle strobes together with the failing word address, a bank indicator and a system-area indicator. The strobes are a corrected single error and a detected double error, each for the low 64-bit half and for the high 64-bit half of a 128-bit word.

When all four event flags are clear, any event sets its flags and stores the failing location with them. The register then locks. Later events are dropped until software clears every set flag by writing 1 to it. A strap selects dual-bank mode, where flash words are 64 bits wide. In that mode the high-half flags never set and read as zero. A double-error flag drives a non-maskable interrupt request. A single-error flag drives a correction interrupt request when software has enabled it.

Software reaches the register over a simple bus with byte strobes, at byte offset 0x18. Reads are combinational. Writes take effect at the clock edge.

Top module: `ecc_capture_reg`

## Requirements
- R1: After reset the register reads 0x0000_0000, and both irq_nmi and irq_corr are low.
- R2: The flag vector sits at bits 31:28 as {low double, low single, high double, high single}. Each flag sets from its own strobe when all four flags were clear before the edge.
- R3: While any flag is set, new events change no flag and no address field.
- R4: Writing 1 to a flag bit with byte strobe 3 asserted clears that flag. Writing 0 leaves the flag unchanged.
- R5: While dual_bank is 1, the high-half strobes never set bits 29 or 28.
- R6: irq_nmi is high exactly while bit 31 or bit 29 is set.
- R7: irq_corr is high only while bit 24 (the read/write enable, written through byte strobe 3) is 1 and bit 30 or bit 28 is set.
- R8: The failing address (bits 20:0), the bank bit (bit 21) and the system-area bit (bit 22) load only in the cycle in which a flag sets. They keep their value after the flags are cleared.
- R9: Several strobes in one unlocked cycle set all of their flags together, and only one address is recorded.
- R10: An event in the same cycle as a write that carries a 1 in any flag bit is not captured.
- R11: Byte lanes 0 to 2 cannot change the register, and bits 27:25 and 23 always read zero.
- R12: bus_rdata is zero unless a read (bus_sel=1, bus_wr=0) addresses word offset 0x18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ev_sec_lo | input | 1 | Corrected single error, low half |
| ev_ded_lo | input | 1 | Detected double error, low half |
| ev_sec_hi | input | 1 | Corrected single error, high half |
| ev_ded_hi | input | 1 | Detected double error, high half |
| ev_addr | input | 21 | Failing word address |
| ev_bank | input | 1 | Bank of the failing access |
| ev_sys | input | 1 | Failing access hit the system area |
| dual_bank | input | 1 | Dual-bank mode strap |
| irq_nmi | output | 1 | Non-maskable interrupt request |
| irq_corr | output | 1 | Correction interrupt request |

## Verification
A corrupted flag shows up in the same cycle on irq_nmi or irq_corr, and at the next read of bits 31:28. A flag stuck high also hides every later event, so the next vector reads back a stale flag set and a stale address. A lock that releases too early shows up one read later as a second event's address overwriting the first. A clear that fails shows up as the flags reading back set after a write-1.

// File: rtl/ecc_cap_pkg.sv
// Package: shared bit positions and widths for the ECC capture register.
// Assumes a 32-bit register image; the flag vector index i maps to bit FLAG_BASE+i.
package ecc_cap_pkg;
    localparam int FLAG_N    = 4;
    localparam int FADDR_W   = 21;
    localparam int FLAG_BASE = 28;
    localparam int IE_BIT    = 24;
    localparam int BANK_BIT  = 21;
    localparam int SYS_BIT   = 22;
    // Flag vector order, low index first: high single, high double, low single, low double
    localparam int F_SEC_HI  = 0;
    localparam int F_DED_HI  = 1;
    localparam int F_SEC_LO  = 2;
    localparam int F_DED_LO  = 3;
    localparam logic [FLAG_N-1:0] HI_MASK = 4'b0011;
endpackage

// File: rtl/ecc_cap_bus.sv
// Module: register bus decode for the ECC capture register.
// Produces per-flag clear strobes and the enable-bit write, and drives read data.
// Assumes byte addressing and one register word at REG_OFFSET.
module ecc_cap_bus
    import ecc_cap_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h18
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] reg_image,
    output logic [FLAG_N-1:0] clr_mask,
    output logic              ie_we,
    output logic              ie_wval,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int FLAG_LANE = FLAG_BASE / 8;
    localparam int IE_LANE   = IE_BIT / 8;

    logic hit;
    logic wr_hit;
    logic unused_bits;

    // Purpose: word-address match for this register
    always_comb hit = bus_sel && (bus_addr[ADDR_W-1:2] == REG_OFFSET[ADDR_W-1:2]);

    // Purpose: qualify a write to this register
    always_comb wr_hit = hit && bus_wr;

    // Purpose: one write-1-to-clear strobe per flag, gated by its byte lane
    for (genvar i = 0; i < FLAG_N; i++) begin : g_clr
        always_comb clr_mask[i] = wr_hit && bus_be[FLAG_LANE] && bus_wdata[FLAG_BASE+i];
    end

    // Purpose: interrupt-enable write through its byte lane
    always_comb begin
        ie_we   = wr_hit && bus_be[IE_LANE];
        ie_wval = bus_wdata[IE_BIT];
    end

    // Purpose: read data only on a read hit
    always_comb bus_rdata = (hit && !bus_wr) ? reg_image : '0;

    assign unused_bits = ^{bus_be, bus_wdata, bus_addr[1:0]};
endmodule

// File: rtl/ecc_cap_gate.sv
// Module: event qualification. Masks high-half strobes in dual-bank mode and
// blocks capture while locked or while a clearing write is in progress.
module ecc_cap_gate
    import ecc_cap_pkg::*;
(
    input  logic [FLAG_N-1:0] ev_vec,
    input  logic              dual_bank,
    input  logic [FLAG_N-1:0] flags_q,
    input  logic [FLAG_N-1:0] clr_mask,
    output logic [FLAG_N-1:0] set_vec,
    output logic              capture
);
    logic [FLAG_N-1:0] eligible;
    logic              open_win;

    // Purpose: drop high-half events when words are 64 bits wide
    always_comb eligible = dual_bank ? (ev_vec & ~HI_MASK) : ev_vec;

    // Purpose: capture window is open only with all flags clear and no clear in flight
    always_comb open_win = (flags_q == '0) && (clr_mask == '0);

    // Purpose: flags to set and the shared location-capture strobe
    always_comb begin
        set_vec = open_win ? eligible : '0;
        capture = |set_vec;
    end
endmodule

// File: rtl/ecc_cap_store.sv
// Module: state of the ECC capture register: event flags, correction-interrupt
// enable and the locked failing location. Synchronous active-low reset.
module ecc_cap_store
    import ecc_cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FLAG_N-1:0]  set_vec,
    input  logic               capture,
    input  logic [FLAG_N-1:0]  clr_mask,
    input  logic               ie_we,
    input  logic               ie_wval,
    input  logic [FADDR_W-1:0] ev_addr,
    input  logic               ev_bank,
    input  logic               ev_sys,
    input  logic               dual_bank,
    output logic [FLAG_N-1:0]  flags_q,
    output logic               ie_q,
    output logic [FADDR_W-1:0] addr_q,
    output logic               bank_q,
    output logic               sys_q
);
    // Purpose: one flag register per event, clear taking priority over set
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)           flags_q[i] <= 1'b0;
            else if (clr_mask[i]) flags_q[i] <= 1'b0;
            else if (set_vec[i])  flags_q[i] <= 1'b1;
        end
    end

    // Purpose: correction-interrupt enable, software read/write
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= 1'b0;
        else if (ie_we) ie_q <= ie_wval;
    end

    // Purpose: failing location, loaded only with a permitted flag set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            bank_q <= 1'b0;
            sys_q  <= 1'b0;
        end else if (capture) begin
            addr_q <= ev_addr;
            bank_q <= ev_bank;
            sys_q  <= ev_sys;
        end
    end

    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q != '0) && (clr_mask == '0)) |=> (flags_q == $past(flags_q)));

    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((flags_q & $past(clr_mask)) == '0));

    p_dual_hi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_bank && ((flags_q & HI_MASK) == '0)) |=> ((flags_q & HI_MASK) == '0));

    p_loc_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q != '0) |=> $stable({addr_q, bank_q, sys_q}));

    p_capture_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|flags_q) |-> (addr_q == $past(ev_addr)));
endmodule

// File: rtl/ecc_capture_reg.sv
// Module: top of the flash ECC error capture register. Records the first
// decoder event, locks until software clears all flags, raises interrupts.
// Assumes decoder strobes are single-cycle and synchronous to clk.
module ecc_capture_reg
    import ecc_cap_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                ev_sec_lo,
    input  logic                ev_ded_lo,
    input  logic                ev_sec_hi,
    input  logic                ev_ded_hi,
    input  logic [FADDR_W-1:0]  ev_addr,
    input  logic                ev_bank,
    input  logic                ev_sys,
    input  logic                dual_bank,
    output logic                irq_nmi,
    output logic                irq_corr
);
    logic [FLAG_N-1:0]  ev_vec;
    logic [FLAG_N-1:0]  clr_mask;
    logic [FLAG_N-1:0]  set_vec;
    logic [FLAG_N-1:0]  flags_q;
    logic               capture;
    logic               ie_we;
    logic               ie_wval;
    logic               ie_q;
    logic [FADDR_W-1:0] addr_q;
    logic               bank_q;
    logic               sys_q;
    logic [DATA_W-1:0]  reg_image;

    // Purpose: pack decoder strobes in flag-vector order
    always_comb begin
        ev_vec           = '0;
        ev_vec[F_DED_LO] = ev_ded_lo;
        ev_vec[F_SEC_LO] = ev_sec_lo;
        ev_vec[F_DED_HI] = ev_ded_hi;
        ev_vec[F_SEC_HI] = ev_sec_hi;
    end

    ecc_cap_bus #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_bus (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .reg_image (reg_image),
        .clr_mask  (clr_mask),
        .ie_we     (ie_we),
        .ie_wval   (ie_wval),
        .bus_rdata (bus_rdata)
    );

    ecc_cap_gate u_gate (
        .ev_vec    (ev_vec),
        .dual_bank (dual_bank),
        .flags_q   (flags_q),
        .clr_mask  (clr_mask),
        .set_vec   (set_vec),
        .capture   (capture)
    );

    ecc_cap_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .capture   (capture),
        .clr_mask  (clr_mask),
        .ie_we     (ie_we),
        .ie_wval   (ie_wval),
        .ev_addr   (ev_addr),
        .ev_bank   (ev_bank),
        .ev_sys    (ev_sys),
        .dual_bank (dual_bank),
        .flags_q   (flags_q),
        .ie_q      (ie_q),
        .addr_q    (addr_q),
        .bank_q    (bank_q),
        .sys_q     (sys_q)
    );

    // Purpose: assemble the software-visible image; unlisted bits stay zero
    always_comb begin
        reg_image                          = '0;
        reg_image[FLAG_BASE +: FLAG_N]     = flags_q;
        reg_image[IE_BIT]                  = ie_q;
        reg_image[SYS_BIT]                 = sys_q;
        reg_image[BANK_BIT]                = bank_q;
        reg_image[FADDR_W-1:0]             = addr_q;
    end

    // Purpose: interrupt requests from the flag state
    always_comb begin
        irq_nmi  = flags_q[F_DED_LO] | flags_q[F_DED_HI];
        irq_corr = ie_q & (flags_q[F_SEC_LO] | flags_q[F_SEC_HI]);
    end

    p_nmi_from_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ded_lo && (flags_q == '0) && (clr_mask == '0)) |=> irq_nmi);

    p_corr_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_we && !ie_wval) |=> !irq_corr);
endmodule

// File: tb/ecc_capture_reg_bench.sv
`timescale 1ns/1ps
module ecc_capture_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h18;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_sec_lo = 1'b0, ev_ded_lo = 1'b0, ev_sec_hi = 1'b0, ev_ded_hi = 1'b0;
    logic [20:0] ev_addr = '0;
    logic        ev_bank = 1'b0, ev_sys = 1'b0, dual_bank = 1'b0;
    logic        irq_nmi, irq_corr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ecc_capture_reg u_ecc_capture_reg (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ev_sec_lo(ev_sec_lo), .ev_ded_lo(ev_ded_lo),
        .ev_sec_hi(ev_sec_hi), .ev_ded_hi(ev_ded_hi), .ev_addr(ev_addr),
        .ev_bank(ev_bank), .ev_sys(ev_sys), .dual_bank(dual_bank),
        .irq_nmi(irq_nmi), .irq_corr(irq_corr)
    );

    // ev order {low double, low single, high double, high single}
    typedef struct packed {
        logic [3:0]  ev;
        logic        dual;
        logic [20:0] addr;
        logic        bank;
        logic        sys;
        logic        ie;
        logic [31:0] exp;
        logic        nmi;
        logic        corr;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{4'b0100, 1'b0, 21'h012345, 1'b0, 1'b0, 1'b1, 32'h4101_2345, 1'b0, 1'b1},
        '{4'b1000, 1'b0, 21'h1FFFFF, 1'b1, 1'b0, 1'b0, 32'h803F_FFFF, 1'b1, 1'b0},
        '{4'b0001, 1'b0, 21'h000001, 1'b0, 1'b1, 1'b0, 32'h1040_0001, 1'b0, 1'b0},
        '{4'b0010, 1'b0, 21'h0ABCDE, 1'b1, 1'b1, 1'b1, 32'h216A_BCDE, 1'b1, 1'b0},
        '{4'b0011, 1'b1, 21'h100000, 1'b0, 1'b0, 1'b1, 32'h016A_BCDE, 1'b0, 1'b0},
        '{4'b1111, 1'b0, 21'h054321, 1'b0, 1'b0, 1'b1, 32'hF105_4321, 1'b1, 1'b1},
        '{4'b1101, 1'b1, 21'h000F0F, 1'b1, 1'b0, 1'b0, 32'hC020_0F0F, 1'b1, 1'b0},
        '{4'b0110, 1'b1, 21'h1F0000, 1'b0, 1'b1, 1'b1, 32'h415F_0000, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic fire(input logic [3:0] ev, input logic dual, input logic [20:0] a,
                        input logic bk, input logic sy);
        @(negedge clk);
        {ev_ded_lo, ev_sec_lo, ev_ded_hi, ev_sec_hi} = ev;
        dual_bank = dual; ev_addr = a; ev_bank = bk; ev_sys = sy;
        @(negedge clk);
        {ev_ded_lo, ev_sec_lo, ev_ded_hi, ev_sec_hi} = 4'b0000;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(8'h18, d);
        check("R1 reset image", d, 32'h0);
        check("R1 reset irqs", {30'b0, irq_nmi, irq_corr}, 32'h0);

        // Table walk: R2, R5, R6, R7, R8, R9
        for (int i = 0; i < 8; i++) begin
            bus_write(8'h18, {7'b0, VECS[i].ie, 24'b0}, 4'b1000);
            fire(VECS[i].ev, VECS[i].dual, VECS[i].addr, VECS[i].bank, VECS[i].sys);
            bus_read(8'h18, d);
            check($sformatf("R2 R5 R8 R9 vector %0d image", i), d, VECS[i].exp);
            check($sformatf("R6 vector %0d nmi", i), {31'b0, irq_nmi}, {31'b0, VECS[i].nmi});
            check($sformatf("R7 vector %0d corr", i), {31'b0, irq_corr}, {31'b0, VECS[i].corr});
            bus_write(8'h18, {4'hF, 3'b0, VECS[i].ie, 24'b0}, 4'b1000);
            bus_read(8'h18, d);
            check($sformatf("R4 vector %0d cleared", i), {28'b0, d[31:28]}, 32'h0);
        end

        // R3: second event while locked is dropped
        dual_bank = 1'b0;
        bus_write(8'h18, 32'h0, 4'b1000);
        fire(4'b0100, 1'b0, 21'h00AAAA, 1'b0, 1'b0);
        fire(4'b1000, 1'b0, 21'h155555, 1'b1, 1'b1);
        bus_read(8'h18, d);
        check("R3 locked image", d, 32'h4000_AAAA);
        check("R3 no nmi", {31'b0, irq_nmi}, 32'h0);

        // R7: enable toggles correction request
        bus_write(8'h18, 32'h0100_0000, 4'b1000);
        check("R7 enabled corr", {31'b0, irq_corr}, 32'h1);
        bus_write(8'h18, 32'h0000_0000, 4'b1000);
        check("R7 disabled corr", {31'b0, irq_corr}, 32'h0);

        // R4: writing zeros leaves the flag
        bus_read(8'h18, d);
        check("R4 write zero keeps flag", d, 32'h4000_AAAA);

        // R11: lower lanes and reserved bits
        bus_write(8'h18, 32'hFFFF_FFFF, 4'b0111);
        bus_read(8'h18, d);
        check("R11 lower lanes ignored", d, 32'h4000_AAAA);
        bus_write(8'h18, 32'h0E80_0000, 4'b1100);
        bus_read(8'h18, d);
        check("R11 reserved read zero", d, 32'h4000_AAAA);

        // R4: clearing an unset flag leaves the set one
        bus_write(8'h18, 32'h8000_0000, 4'b1000);
        bus_read(8'h18, d);
        check("R4 other flag kept", d, 32'h4000_AAAA);

        // R10: clear and event in the same cycle; event lost
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h4000_0000; bus_be = 4'b1000;
        ev_ded_lo = 1'b1; ev_addr = 21'h012345; ev_bank = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0; ev_ded_lo = 1'b0;
        bus_read(8'h18, d);
        check("R10 event lost", d, 32'h0000_AAAA);
        check("R10 no nmi", {31'b0, irq_nmi}, 32'h0);

        // R2 R8: capture works again once clear
        fire(4'b1000, 1'b0, 21'h012345, 1'b0, 1'b0);
        bus_read(8'h18, d);
        check("R2 recapture", d, 32'h8001_2345);
        check("R6 nmi set", {31'b0, irq_nmi}, 32'h1);

        // R12: other word address reads zero
        bus_read(8'h1C, d);
        check("R12 other offset", d, 32'h0);
        bus_write(8'h1C, 32'hF000_0000, 4'b1000);
        bus_read(8'h18, d);
        check("R12 other offset write ignored", d, 32'h8001_2345);

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(8'h18, d);
        check("R1 re-reset image", d, 32'h0);
        check("R1 re-reset nmi", {31'b0, irq_nmi}, 32'h0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule